// File: doc/BRIEF.md
# Event Tally with Snapshot Register

This block counts single-cycle event strobes in a saturating counter and, on an update strobe, moves the running total into a holding register while restarting the count from zero in that same cycle. The holding register gives a stable figure for the last interval. The running counter keeps accumulating the next interval with no lost events, including an event that arrives in the update cycle itself.

Three status indications come with the count. One is live and is high while the running count is non-zero. Two are sticky: one records that the count left zero, the other records that any increment took place. Each sticky flag has its own clear strobe. A set condition in the same cycle as a clear wins. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `evt_tally_snap`

## Requirements
- R1: Each cycle with `evt_i` high and `snap_i` low, while the running count is below its maximum, raises the running count by exactly one. The running count is observed through `hold_o` after a snapshot.
- R2: The running count saturates at all ones (2^CNT_W-1). An event at that value leaves the count unchanged and does not set `inc_seen_o`.
- R3: `live_nz_o` is high exactly when the running count is not zero.
- R4: `first_hit_o` sets on the edge where the running count moves from zero to one. This includes a snapshot cycle that also carries an event.
- R5: `inc_seen_o` sets on every edge where the running count is incremented or is reloaded with one.
- R6: A cycle with `snap_i` high copies the running count as it stood before that edge into `hold_o`. On the same edge the running count becomes zero.
- R7: When `snap_i` and `evt_i` are high in the same cycle, the running count becomes one rather than zero.
- R8: `hold_o` keeps its value in every cycle without `snap_i`.
- R9: `clr_first_i` clears `first_hit_o`, and `clr_inc_i` clears `inc_seen_o`, on the following edge. If the flag's set condition is present in that same cycle, the flag is set instead.
- R10: While `rst_n` is low, the count, `hold_o` and all three flags are zero. After `rst_n` rises, two clock edges pass before events are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Event strobe, one count per high cycle |
| snap_i | input | 1 | Update strobe: snapshot and restart |
| clr_first_i | input | 1 | Write-one clear of the zero-to-one flag |
| clr_inc_i | input | 1 | Write-one clear of the increment flag |
| hold_o | output | CNT_W | Snapshot of the running count |
| live_nz_o | output | 1 | Running count is non-zero |
| first_hit_o | output | 1 | Sticky: count left zero |
| inc_seen_o | output | 1 | Sticky: an increment occurred |

## Verification
The bench builds the block with CNT_W = 3, so that saturation at 7 is reached in a handful of events. For every count from 0 to 7, the bench drives all sixteen combinations of event, update and the two clears. This covers the coincident update-with-event reload, updates at saturation, and clear-versus-set races exhaustively. A seeded random stream after that exercises long mixed sequences against an arithmetic model. The release sequence of the reset synchronizer is also checked.

// File: rtl/evt_tally_pkg.sv
package evt_tally_pkg;

  typedef struct packed {
    logic live_nz;
    logic first_hit;
    logic inc_seen;
  } tally_stat_t;

  localparam int unsigned STICKY_N = 2;
  localparam int unsigned STICKY_FIRST = 0;
  localparam int unsigned STICKY_INC = 1;

endpackage

// File: rtl/tally_rst_sync.sv
module tally_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/tally_counter.sv
module tally_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             evt_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             inc_fire_o,
  output logic             rise_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;
  logic             at_max;
  logic             is_zero;

  always_comb begin
    at_max     = (cnt_q == CNT_MAX);
    is_zero    = (cnt_q == '0);
    inc_fire_o = evt_i & (snap_i | ~at_max);
    rise_o     = evt_i & (snap_i | is_zero);
    cnt_en     = snap_i | inc_fire_o;
    if (snap_i) cnt_nxt = evt_i ? CNT_ONE : '0;
    else        cnt_nxt = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;

  AST_SAT_STAYS: assert property (@(posedge clk) disable iff (!srst_n)
    (cnt_q == CNT_MAX && evt_i && !snap_i) |=> (cnt_q == CNT_MAX)); // R2

  AST_SNAP_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (snap_i && !evt_i) |=> (cnt_q == '0)); // R6

  AST_SNAP_RELOAD: assert property (@(posedge clk) disable iff (!srst_n)
    (snap_i && evt_i) |=> (cnt_q == CNT_ONE)); // R7

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!srst_n)
    (!snap_i && cnt_q != '0) |=> (cnt_q != '0)); // R1

endmodule

// File: rtl/tally_hold.sv
module tally_hold #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             snap_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] hold_o
);

  logic [CNT_W-1:0] hold_q;
  logic [CNT_W-1:0] hold_nxt;

  always_comb begin
    hold_nxt = cnt_i;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     hold_q <= '0;
    else if (snap_i) hold_q <= hold_nxt;
  end

  assign hold_o = hold_q;

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!srst_n)
    !snap_i |=> $stable(hold_q)); // R8

endmodule

// File: rtl/tally_sticky.sv
module tally_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic flag_q;
    logic flag_nxt;

    always_comb begin
      flag_nxt = set_i[g] | (flag_q & ~clr_i[g]);
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) flag_q <= 1'b0;
      else         flag_q <= flag_nxt;
    end

    assign flag_o[g] = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!srst_n)
      set_i[g] |=> flag_q); // R9

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!srst_n)
      (clr_i[g] && !set_i[g]) |=> !flag_q); // R9
  end

endmodule

// File: rtl/evt_tally_snap.sv
module evt_tally_snap
  import evt_tally_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             snap_i,
  input  logic             clr_first_i,
  input  logic             clr_inc_i,
  output logic [CNT_W-1:0] hold_o,
  output logic             live_nz_o,
  output logic             first_hit_o,
  output logic             inc_seen_o
);

  logic                srst_n;
  logic [CNT_W-1:0]    cnt;
  logic                inc_fire;
  logic                rise;
  logic [STICKY_N-1:0] st_set;
  logic [STICKY_N-1:0] st_clr;
  logic [STICKY_N-1:0] st_flag;
  tally_stat_t         stat;

  tally_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  tally_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .srst_n     (srst_n),
    .evt_i      (evt_i),
    .snap_i     (snap_i),
    .cnt_o      (cnt),
    .inc_fire_o (inc_fire),
    .rise_o     (rise)
  );

  tally_hold #(.CNT_W(CNT_W)) u_hold (
    .clk    (clk),
    .srst_n (srst_n),
    .snap_i (snap_i),
    .cnt_i  (cnt),
    .hold_o (hold_o)
  );

  always_comb begin
    st_set               = '0;
    st_clr               = '0;
    st_set[STICKY_FIRST] = rise;
    st_set[STICKY_INC]   = inc_fire;
    st_clr[STICKY_FIRST] = clr_first_i;
    st_clr[STICKY_INC]   = clr_inc_i;
  end

  tally_sticky #(.N(STICKY_N)) u_sticky (
    .clk    (clk),
    .srst_n (srst_n),
    .set_i  (st_set),
    .clr_i  (st_clr),
    .flag_o (st_flag)
  );

  always_comb begin
    stat.live_nz   = |cnt;
    stat.first_hit = st_flag[STICKY_FIRST];
    stat.inc_seen  = st_flag[STICKY_INC];
  end

  assign live_nz_o   = stat.live_nz;
  assign first_hit_o = stat.first_hit;
  assign inc_seen_o  = stat.inc_seen;

  AST_NZ_FROM_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (!live_nz_o && evt_i) |=> (live_nz_o && first_hit_o)); // R4

  AST_INC_FLAG: assert property (@(posedge clk) disable iff (!srst_n)
    (evt_i && !live_nz_o) |=> inc_seen_o); // R5

  AST_NZ_DROPS: assert property (@(posedge clk) disable iff (!srst_n)
    (snap_i && !evt_i) |=> !live_nz_o); // R3

endmodule

// File: tb/tb_evt_tally_snap.sv
module tb_evt_tally_snap;

  localparam int unsigned W = 3;
  localparam int unsigned MAXV = (1 << W) - 1;

  logic         clk;
  logic         rst_n;
  logic         evt, snap, cfirst, cinc;
  logic [W-1:0] hold;
  logic         live_nz, first_hit, inc_seen;

  int checks;
  int errors;
  int m_cnt, m_hold;
  bit m_first, m_inc;
  bit done;

  evt_tally_snap #(.CNT_W(W)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt),
    .snap_i      (snap),
    .clr_first_i (cfirst),
    .clr_inc_i   (cinc),
    .hold_o      (hold),
    .live_nz_o   (live_nz),
    .first_hit_o (first_hit),
    .inc_seen_o  (inc_seen)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 R2 R6 R7 R8 hold", int'(hold), m_hold);
    chk("R3 live_nz", int'(live_nz), int'(m_cnt != 0));
    chk("R4 R9 first_hit", int'(first_hit), int'(m_first));
    chk("R5 R9 inc_seen", int'(inc_seen), int'(m_inc));
  endtask

  task automatic cyc(input bit e, input bit s, input bit cf, input bit ci);
    bit inc_now, rise_now;
    evt = e; snap = s; cfirst = cf; cinc = ci;
    @(posedge clk);
    inc_now  = e && (s || m_cnt != MAXV);
    rise_now = e && (s || m_cnt == 0);
    m_first  = rise_now || (m_first && !cf);
    m_inc    = inc_now || (m_inc && !ci);
    if (s) begin
      m_hold = m_cnt;
      m_cnt  = e ? 1 : 0;
    end else if (inc_now) begin
      m_cnt = m_cnt + 1;
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    checks = 0; errors = 0; done = 0;
    m_cnt = 0; m_hold = 0; m_first = 0; m_inc = 0;
    evt = 0; snap = 0; cfirst = 0; cinc = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    // R10: outputs during reset
    chk("R10 hold in reset", int'(hold), 0);
    chk("R10 live_nz in reset", int'(live_nz), 0);
    chk("R10 first_hit in reset", int'(first_hit), 0);
    chk("R10 inc_seen in reset", int'(inc_seen), 0);
    // R10: events during the two release edges are not counted
    evt = 1;
    rst_n = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 live_nz during release", int'(live_nz), 0);
    chk("R10 inc_seen during release", int'(inc_seen), 0);
    evt = 0;
    @(negedge clk);
    compare_all();

    // Exhaustive sweep: every count value against every input combination
    for (int tgt = 0; tgt <= int'(MAXV); tgt++) begin
      for (int combo = 0; combo < 16; combo++) begin
        cyc(0, 1, 1, 1);
        for (int k = 0; k < tgt; k++) cyc(1, 0, 0, 0);
        cyc(combo[0], combo[1], combo[2], combo[3]);
        cyc(0, 0, 0, 0);
        cyc(0, 1, 0, 0);
      end
    end

    // Saturation run: many events past the maximum, then snapshot (R2)
    cyc(0, 1, 1, 1);
    for (int k = 0; k < 20; k++) cyc(1, 0, 0, 0);
    cyc(0, 1, 0, 0);
    chk("R2 saturated snapshot", int'(hold), int'(MAXV));

    // Random mixed stream
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc(r < 60, r % 9 == 0, r % 7 == 0, r % 11 == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule